// File: doc/BRIEF.md
# Inter-Core Mailbox FIFO Pair

Two processor cores exchange 32-bit messages through this block. It holds two one-way queues. The first carries words written by core 0 to core 1. The second carries words written by core 1 to core 0. Each core has its own set of ports:

- a push strobe with push data, feeding its outgoing queue;
- a pop strobe with registered pop data, draining its incoming queue;
- a write strobe for its status word;
- a 32-bit status word;
- an interrupt line.

A core learns from its status word whether a message is waiting and whether its outgoing queue has room. The status word also carries two sticky error flags. One records a push that found the outgoing queue full. The other records a pop that found the incoming queue empty. A core normally reacts to its interrupt by popping every waiting word and then writing its status word to clear any error. A word pushed by one core is seen by the other core one cycle later.

Top module: `mbox_pair`

## Requirements
- R1: Words pushed by core 0 come out of core 1's pop port in the order they were pushed, and words pushed by core 1 come out of core 0's pop port in order. Each queue is 32 bits wide and holds 8 words.
- R2: Pop data changes only on the clock edge that samples a pop strobe. It is valid from that edge onward and holds its value until the next pop.
- R3: Status bit 0 (message waiting) is set from the cycle after a word enters that core's incoming queue. It is clear while that queue is empty.
- R4: Status bit 1 (room) is set while that core's outgoing queue has at least one free slot. It is clear once 8 words sit unread in that queue.
- R5: A push into a full queue with no pop in the same cycle loses the word and leaves the queue unchanged. It sets the pushing core's sticky status bit 2.
- R6: A pop from an empty queue returns zero and sets the popping core's sticky status bit 3.
- R7: A push and a pop on a full queue in the same cycle both succeed. Bit 2 is not set and word order is kept.
- R8: A write strobe on a core's status clears that core's bits 2 and 3 and leaves the other core's flags alone. An error arriving in the same cycle as the clear leaves its flag set.
- R9: A core's interrupt is the OR of its status bits 0, 2 and 3. Bit 1 has no effect on it.
- R10: Status bits 31:4 always read zero. After reset each status word is 0x2, both interrupts are low and both pop data outputs are zero.
- R11: A pop on an empty queue in the same cycle as a push into it returns zero and sets bit 3. The pushed word is kept and is visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c0_push | input | 1 | Core 0 pushes a word toward core 1 |
| c0_push_data | input | 32 | Word from core 0 |
| c0_pop | input | 1 | Core 0 pops a word from core 1 |
| c0_pop_data | output | 32 | Last word popped by core 0 |
| c0_stat_wr | input | 1 | Core 0 status write, clears its error flags |
| c0_status | output | 32 | Core 0 status word |
| c0_irq | output | 1 | Core 0 interrupt |
| c1_push | input | 1 | Core 1 pushes a word toward core 0 |
| c1_push_data | input | 32 | Word from core 1 |
| c1_pop | input | 1 | Core 1 pops a word from core 0 |
| c1_pop_data | output | 32 | Last word popped by core 1 |
| c1_stat_wr | input | 1 | Core 1 status write, clears its error flags |
| c1_status | output | 32 | Core 1 status word |
| c1_irq | output | 1 | Core 1 interrupt |

## Verification
All results come from a single register stage, so each is due one cycle after its stimulus. A strobe that the rising edge samples updates pop data, the room and waiting bits, both sticky flags and the interrupt at that edge. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It then compares every output against that model at the next falling edge, which is half a cycle after the edge that registered the change. Directed checks after each scenario also read the ports at that falling edge, one idle cycle after the last strobe.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int ST_VLD = 0;
  localparam int ST_RDY = 1;
  localparam int ST_WOF = 2;
  localparam int ST_ROE = 3;
  localparam int NUM_CORES = 2;
endpackage

// File: rtl/mbox_fifo.sv
`timescale 1ns/1ps
module mbox_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          empty,
  output logic          full,
  output logic          drop,
  output logic          miss
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          pop_ok, push_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULLC);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign drop    = push && !push_ok;
  assign miss    = pop && empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (pop) begin
      pop_data <= pop_ok ? mem[rptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULLC) else $error("count beyond depth"); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(wptr))) else $error("full push changed queue"); // R5

  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (pop_data == '0)) else $error("empty pop not zero"); // R6

  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
    (full && push && pop) |=> full) else $error("full swap lost a word"); // R7

  AST_PUSH_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    push |=> !empty) else $error("pushed word not visible"); // R3

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pop |=> $stable(pop_data)) else $error("pop data moved without pop"); // R2
endmodule

// File: rtl/mbox_port.sv
`timescale 1ns/1ps
module mbox_port
  import mbox_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_has,
  input  logic          tx_room,
  input  logic          ovf_evt,
  input  logic          udf_evt,
  input  logic          stat_wr,
  output logic [SW-1:0] status,
  output logic          irq
);
  logic wof_q, roe_q;

  // a new error wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      wof_q <= 1'b0;
      roe_q <= 1'b0;
    end else begin
      wof_q <= (wof_q && !stat_wr) || ovf_evt;
      roe_q <= (roe_q && !stat_wr) || udf_evt;
    end
  end

  always_comb begin
    status         = '0;
    status[ST_VLD] = rx_has;
    status[ST_RDY] = tx_room;
    status[ST_WOF] = wof_q;
    status[ST_ROE] = roe_q;
  end

  assign irq = rx_has || wof_q || roe_q;

  AST_WOF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> (status[ST_WOF] && irq)) else $error("overflow flag missing"); // R5

  AST_ROE_STICKY: assert property (@(posedge clk) disable iff (rst)
    udf_evt |=> (status[ST_ROE] && irq)) else $error("underflow flag missing"); // R6

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !ovf_evt && !udf_evt) |=> (!status[ST_WOF] && !status[ST_ROE])) else $error("clear failed"); // R8

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stat_wr && status[ST_WOF]) |=> status[ST_WOF]) else $error("overflow flag not sticky"); // R5
endmodule

// File: rtl/mbox_pair.sv
`timescale 1ns/1ps
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int SW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          c0_push,
  input  logic [DW-1:0] c0_push_data,
  input  logic          c0_pop,
  output logic [DW-1:0] c0_pop_data,
  input  logic          c0_stat_wr,
  output logic [SW-1:0] c0_status,
  output logic          c0_irq,
  input  logic          c1_push,
  input  logic [DW-1:0] c1_push_data,
  input  logic          c1_pop,
  output logic [DW-1:0] c1_pop_data,
  input  logic          c1_stat_wr,
  output logic [SW-1:0] c1_status,
  output logic          c1_irq
);
  // queue d is written by core d and read by the other core
  logic [NUM_CORES-1:0] push_v, pop_v, swr_v;
  logic [NUM_CORES-1:0] empty_v, full_v, drop_v, miss_v, irq_v;
  logic [DW-1:0]        wdat_v [NUM_CORES];
  logic [DW-1:0]        rdat_v [NUM_CORES];
  logic [SW-1:0]        stat_v [NUM_CORES];

  assign push_v    = {c1_push, c0_push};
  assign pop_v     = {c1_pop, c0_pop};
  assign swr_v     = {c1_stat_wr, c0_stat_wr};
  assign wdat_v[0] = c0_push_data;
  assign wdat_v[1] = c1_push_data;

  genvar g;
  generate
    for (g = 0; g < NUM_CORES; g++) begin : g_core
      mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push_v[g]),
        .push_data (wdat_v[g]),
        .pop       (pop_v[NUM_CORES-1-g]),
        .pop_data  (rdat_v[g]),
        .empty     (empty_v[g]),
        .full      (full_v[g]),
        .drop      (drop_v[g]),
        .miss      (miss_v[g])
      );

      mbox_port #(.SW(SW)) u_port (
        .clk     (clk),
        .rst     (rst),
        .rx_has  (!empty_v[NUM_CORES-1-g]),
        .tx_room (!full_v[g]),
        .ovf_evt (drop_v[g]),
        .udf_evt (miss_v[NUM_CORES-1-g]),
        .stat_wr (swr_v[g]),
        .status  (stat_v[g]),
        .irq     (irq_v[g])
      );
    end
  endgenerate

  assign c0_pop_data = rdat_v[1];
  assign c1_pop_data = rdat_v[0];
  assign c0_status   = stat_v[0];
  assign c1_status   = stat_v[1];
  assign c0_irq      = irq_v[0];
  assign c1_irq      = irq_v[1];

  AST_CROSS_VLD: assert property (@(posedge clk) disable iff (rst)
    c0_push |=> c1_status[ST_VLD]) else $error("core 1 did not see word"); // R3

  AST_OTHER_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    (c0_stat_wr && !c1_stat_wr && c1_status[ST_ROE]) |=> c1_status[ST_ROE]) else $error("clear leaked"); // R8
endmodule

// File: tb/mbox_pair_tb.sv
`timescale 1ns/1ps
module mbox_pair_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        c0_push = 0, c0_pop = 0, c0_stat_wr = 0;
  logic        c1_push = 0, c1_pop = 0, c1_stat_wr = 0;
  logic [31:0] c0_push_data = '0, c1_push_data = '0;
  logic [31:0] c0_pop_data, c1_pop_data, c0_status, c1_status;
  logic        c0_irq, c1_irq;

  always #5 clk = ~clk;

  mbox_pair u_dut (
    .clk(clk), .rst(rst),
    .c0_push(c0_push), .c0_push_data(c0_push_data), .c0_pop(c0_pop),
    .c0_pop_data(c0_pop_data), .c0_stat_wr(c0_stat_wr), .c0_status(c0_status), .c0_irq(c0_irq),
    .c1_push(c1_push), .c1_push_data(c1_push_data), .c1_pop(c1_pop),
    .c1_pop_data(c1_pop_data), .c1_stat_wr(c1_stat_wr), .c1_status(c1_status), .c1_irq(c1_irq)
  );

  int total = 0;
  int fails = 0;
  bit done  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, advanced at the rising edge
  logic [31:0] q01 [$];
  logic [31:0] q10 [$];
  logic [31:0] e_pd0, e_pd1;
  bit e_wof0, e_wof1, e_roe0, e_roe1, mon_en, pp0, pp1;
  bit ok01, ok10, room01, room10;

  always @(posedge clk) begin
    if (rst) begin
      q01.delete(); q10.delete();
      e_pd0 = '0; e_pd1 = '0;
      e_wof0 = 0; e_wof1 = 0; e_roe0 = 0; e_roe1 = 0;
      mon_en = 0; pp0 = 0; pp1 = 0;
    end else begin
      mon_en = 1;
      pp0 = c0_pop; pp1 = c1_pop;
      ok01   = c1_pop && (q01.size() > 0);
      room01 = (q01.size() < DEPTH) || ok01;
      ok10   = c0_pop && (q10.size() > 0);
      room10 = (q10.size() < DEPTH) || ok10;
      if (c1_pop) e_pd1 = ok01 ? q01.pop_front() : 32'h0;
      if (c0_pop) e_pd0 = ok10 ? q10.pop_front() : 32'h0;
      if (c0_push && room01) q01.push_back(c0_push_data);
      if (c1_push && room10) q10.push_back(c1_push_data);
      e_roe1 = (e_roe1 && !c1_stat_wr) || (c1_pop && !ok01);
      e_roe0 = (e_roe0 && !c0_stat_wr) || (c0_pop && !ok10);
      e_wof0 = (e_wof0 && !c0_stat_wr) || (c0_push && !room01);
      e_wof1 = (e_wof1 && !c1_stat_wr) || (c1_push && !room10);
    end
  end

  // monitor: compares every output half a cycle after the edge
  always @(negedge clk) begin
    if (mon_en && !done) begin
      chk(pp0 ? "R1 c0 data" : "R2 c0 data hold", c0_pop_data, e_pd0);
      chk(pp1 ? "R1 c1 data" : "R2 c1 data hold", c1_pop_data, e_pd1);
      chk("R3 c0 waiting", {31'b0, c0_status[0]}, {31'b0, q10.size() > 0});
      chk("R3 c1 waiting", {31'b0, c1_status[0]}, {31'b0, q01.size() > 0});
      chk("R4 c0 room", {31'b0, c0_status[1]}, {31'b0, q01.size() < DEPTH});
      chk("R4 c1 room", {31'b0, c1_status[1]}, {31'b0, q10.size() < DEPTH});
      chk("R5 c0 overflow", {31'b0, c0_status[2]}, {31'b0, e_wof0});
      chk("R5 c1 overflow", {31'b0, c1_status[2]}, {31'b0, e_wof1});
      chk("R6 c0 underflow", {31'b0, c0_status[3]}, {31'b0, e_roe0});
      chk("R6 c1 underflow", {31'b0, c1_status[3]}, {31'b0, e_roe1});
      chk("R10 c0 upper", {4'b0, c0_status[31:4]}, 32'h0);
      chk("R10 c1 upper", {4'b0, c1_status[31:4]}, 32'h0);
      chk("R9 c0 irq", {31'b0, c0_irq}, {31'b0, (q10.size() > 0) || e_wof0 || e_roe0});
      chk("R9 c1 irq", {31'b0, c1_irq}, {31'b0, (q01.size() > 0) || e_wof1 || e_roe1});
    end
  end

  // driver: applies one cycle of strobes at the falling edge
  task automatic cyc(input logic p0, input logic [31:0] d0, input logic r0, input logic s0,
                     input logic p1, input logic [31:0] d1, input logic r1, input logic s1);
    @(negedge clk);
    c0_push = p0; c0_push_data = d0; c0_pop = r0; c0_stat_wr = s0;
    c1_push = p1; c1_push_data = d1; c1_pop = r1; c1_stat_wr = s1;
  endtask

  task automatic idle();
    cyc(0, 32'h0, 0, 0, 0, 32'h0, 0, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    idle();
    // reset state
    chk("R10 reset status c0", c0_status, 32'h2);
    chk("R10 reset status c1", c1_status, 32'h2);
    chk("R10 reset data", c0_pop_data | c1_pop_data, 32'h0);
    chk("R9 room alone no irq", {30'b0, c1_irq, c0_irq}, 32'h0);

    // core 0 sends three words; core 1 pops four
    for (int i = 0; i < 3; i++) cyc(1, 32'hA000_0000 + i, 0, 0, 0, 0, 0, 0);
    idle();
    chk("R3 c1 sees words", {31'b0, c1_status[0]}, 32'h1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0);
    idle();
    chk("R6 empty pop zero", c1_pop_data, 32'h0);
    chk("R6 underflow set", {31'b0, c1_status[3]}, 32'h1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle();
    chk("R8 c1 cleared", {28'b0, c1_status[3:0]}, 32'h2);

    // core 1 fills toward core 0 past capacity
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 1, 32'hB000_0000 + i, 0, 0);
    idle();
    chk("R4 room gone", {31'b0, c1_status[1]}, 32'h0);
    chk("R5 overflow set", {31'b0, c1_status[2]}, 32'h1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle();
    // push and pop together on a full queue
    cyc(0, 0, 1, 0, 1, 32'hC0DE_0001, 0, 0);
    idle();
    chk("R7 no overflow on swap", {31'b0, c1_status[2]}, 32'h0);
    chk("R7 still full", {31'b0, c1_status[1]}, 32'h0);
    chk("R7 oldest out", c0_pop_data, 32'hB000_0000);
    for (int i = 0; i < 9; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0);
    idle();
    chk("R6 c0 underflow", {31'b0, c0_status[3]}, 32'h1);

    // pop on empty while the other side pushes
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 1, 32'h1234_5678, 0, 0);
    idle();
    chk("R11 pop zero", c0_pop_data, 32'h0);
    chk("R11 underflow", {31'b0, c0_status[3]}, 32'h1);
    chk("R11 word kept", {31'b0, c0_status[0]}, 32'h1);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    // clear and new error in the same cycle
    cyc(0, 0, 1, 1, 0, 0, 0, 0);
    idle();
    chk("R8 error beats clear", {31'b0, c0_status[3]}, 32'h1);
    chk("R11 late word", c0_pop_data, 32'h0);

    // mixed traffic on both sides
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], {lf, ~lf}, lf[1], lf[2] & lf[3] & lf[4],
          lf[5], {~lf, lf}, lf[6], lf[7] & lf[8] & lf[9]);
    end
    idle();
    idle();
    done = 1;
    report();
  end
endmodule